// File: doc/BRIEF.md
# Receive Input Conditioning Path

This block sits at the front of a digital receiver. It accepts four 16-bit sample ports, named A to D and indexed 0 to 3, that already run in the receive clock domain. A shared valid strobe marks each sample. Every port is turned into signed data from either offset-binary or two's complement. The result is placed in an 18-bit field with its top bit at a programmable position, which leaves headroom for later gain stages.

The converted ports are then routed onto four output lanes. In real mode each port feeds its own lane. In complex mode the lanes form two I/Q pairs, and any port can be chosen for any lane. Each lane ends in a circular buffer that delays it by a programmable 1 to 64 valid samples. All four lanes leave together on an 18-bit-per-lane bus with one valid strobe.

Configuration is captured only while reset or the load strobe is high. The host holds the sample stream idle during a load.

Top module: `rx_input_cond`

## Requirements
- R1: During and after reset `out_valid` is 0 and `out_data` is all zero. Each lane's first outputs after reset, before the lane has received as many valid samples as its delay, are zero.
- R2: `cfg_offbin[p]`=1 makes port p offset-binary: its bit 15 is inverted before the value is read as signed. With `cfg_offbin[p]`=0 the 16 bits pass through as two's complement.
- R3: The signed 16-bit port value fills bits 17:2 of the 18-bit lane field with zeros below. It is then shifted right arithmetically by `cfg_shift[3p+2:3p]`, where values 5 to 7 act as 4.
- R4: With `cfg_cplx`=0, lane k carries port k. Lane k sits at `out_data[18k+17:18k]` and port k at `in_data[16k+15:16k]`.
- R5: With `cfg_cplx`=1, lane k carries the port numbered by `cfg_iq_sel[2k+1:2k]`. Lanes 0/1 are I/Q of pair 0 and lanes 2/3 are I/Q of pair 1.
- R6: A delay field value f in `cfg_dly[6k+5:6k]` gives a delay of f+1. At the n-th valid output (counting from 0 after reset) lane k carries the sample that entered at valid input n-(f+1), or zero when that index is negative.
- R7: With `cfg_cplx`=1, lanes 1 and 3 use the delay fields of lanes 0 and 2, and their own fields are ignored.
- R8: `out_valid` is high exactly two cycles after each `in_valid`. Buffer positions advance only on valid samples.
- R9: With `cfg_tbus_en`=1, every lane whose source is port C or D (index 2 or 3) carries zero.
- R10: Configuration inputs are captured only on clock edges where `rst` or `cfg_load` is high. Changes at other times have no effect. A load leaves the buffered samples in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset, also captures configuration |
| cfg_load | input | 1 | Captures configuration while the stream is idle |
| cfg_offbin | input | 4 | Per-port offset-binary select |
| cfg_shift | input | 12 | Per-port 3-bit headroom shift |
| cfg_cplx | input | 1 | Complex (I/Q) lane mode |
| cfg_iq_sel | input | 8 | Per-lane 2-bit source port in complex mode |
| cfg_tbus_en | input | 1 | Ports C and D unavailable as inputs |
| cfg_dly | input | 24 | Per-lane 6-bit delay field (delay = field + 1) |
| in_valid | input | 1 | Sample strobe for all ports |
| in_data | input | 64 | Four 16-bit port samples |
| out_valid | output | 1 | Output strobe for all lanes |
| out_data | output | 72 | Four 18-bit signed lane samples |

## Verification
The delicate coincidence is the buffer write of the newest sample landing in the same cycle as the read of the oldest one. This happens when a lane is set to the full 64-sample delay, because the read and write slots are then the same. The bench provokes it by giving one lane delay field 63 under long runs of nearly continuous valid samples, next to a lane with delay 1. It judges each output against a bench-side history of converted samples taken exactly 64 valid samples earlier. A second coincidence, a configuration change with no load strobe while samples flow, is judged by requiring outputs to keep following the old settings.

// File: rtl/rxc_pkg.sv
package rxc_pkg;

  typedef enum logic {
    LANE_REAL = 1'b0,
    LANE_CPLX = 1'b1
  } lane_mode_e;

  // Limit a requested right shift to the largest supported headroom step.
  function automatic int clamp_shift(input int req, input int limit);
    return (req > limit) ? limit : req;
  endfunction

endpackage

// File: rtl/rxc_port_fmt.sv
module rxc_port_fmt
  import rxc_pkg::*;
#(
  parameter int IN_W      = 16,
  parameter int OUT_W     = 18,
  parameter int SH_W      = 3,
  parameter int SHIFT_MAX = 4
) (
  input  logic [IN_W-1:0]  raw,
  input  logic             offbin,
  input  logic [SH_W-1:0]  shift,
  output logic [OUT_W-1:0] conv
);

  localparam int PAD_W = OUT_W - IN_W;

  logic [IN_W-1:0]         signed_word;
  logic signed [OUT_W-1:0] justified;
  logic [SH_W-1:0]         sh_eff;

  always_comb begin
    signed_word            = raw;
    signed_word[IN_W-1]    = raw[IN_W-1] ^ offbin;
    justified              = {signed_word, {PAD_W{1'b0}}};
    sh_eff                 = SH_W'(clamp_shift(int'(shift), SHIFT_MAX));
    conv                   = justified >>> sh_eff;
  end

endmodule

// File: rtl/rxc_lane_map.sv
module rxc_lane_map #(
  parameter int N     = 4,
  parameter int W     = 18,
  parameter int SEL_W = 2
) (
  input  logic [W-1:0]       port_v [N],
  input  logic               cplx,
  input  logic [N*SEL_W-1:0] sel,
  input  logic               tbus,
  output logic [W-1:0]       lane_v [N]
);

  localparam int FIRST_SHARED = N - 2;

  always_comb begin
    for (int k = 0; k < N; k++) begin
      logic [SEL_W-1:0] src;
      src = cplx ? sel[k*SEL_W +: SEL_W] : SEL_W'(k);
      if (tbus && (int'(src) >= FIRST_SHARED)) lane_v[k] = '0;
      else                                     lane_v[k] = port_v[src];
    end
  end

endmodule

// File: rtl/rxc_delay_line.sv
module rxc_delay_line #(
  parameter int W     = 18,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          din_valid,
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] dly,
  output logic          dout_valid,
  output logic [W-1:0]  dout
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q;
  logic [AW:0]   fill_q;
  logic [AW:0]   dly_len;
  logic [AW-1:0] raddr;
  logic [W-1:0]  rd_word;

  assign dly_len = {1'b0, dly} + (AW+1)'(1);
  assign raddr   = wptr_q - dly - AW'(1);
  assign rd_word = mem[raddr];

  // Storage without reset so it maps onto RAM; the fill counter masks unwritten slots.
  always_ff @(posedge clk) begin
    if (din_valid) mem[wptr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q     <= '0;
      fill_q     <= '0;
      dout_valid <= 1'b0;
      dout       <= '0;
    end else begin
      dout_valid <= din_valid;
      if (din_valid) begin
        wptr_q <= wptr_q + AW'(1);
        if (fill_q != (AW+1)'(DEPTH)) fill_q <= fill_q + (AW+1)'(1);
        dout   <= (fill_q >= dly_len) ? rd_word : '0;
      end
    end
  end

  assert_valid_follow_R8: assert property (@(posedge clk) disable iff (rst)
    din_valid |=> dout_valid);
  assert_no_spurious_R8: assert property (@(posedge clk) disable iff (rst)
    !din_valid |=> !dout_valid);
  assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !din_valid |=> $stable(wptr_q));
  assert_unfilled_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (din_valid && (fill_q < dly_len)) |=> (dout == '0));
  assert_fill_bound_R6: assert property (@(posedge clk) disable iff (rst)
    fill_q <= (AW+1)'(DEPTH));

endmodule

// File: rtl/rx_input_cond.sv
module rx_input_cond
  import rxc_pkg::*;
#(
  parameter int N_PORTS   = 4,
  parameter int IN_W      = 16,
  parameter int OUT_W     = 18,
  parameter int MAX_DLY   = 64,
  parameter int SHIFT_MAX = 4,
  localparam int SH_W     = $clog2(SHIFT_MAX + 1),
  localparam int DLY_W    = $clog2(MAX_DLY),
  localparam int SEL_W    = $clog2(N_PORTS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_load,
  input  logic [N_PORTS-1:0]         cfg_offbin,
  input  logic [N_PORTS*SH_W-1:0]    cfg_shift,
  input  logic                       cfg_cplx,
  input  logic [N_PORTS*SEL_W-1:0]   cfg_iq_sel,
  input  logic                       cfg_tbus_en,
  input  logic [N_PORTS*DLY_W-1:0]   cfg_dly,
  input  logic                       in_valid,
  input  logic [N_PORTS*IN_W-1:0]    in_data,
  output logic                       out_valid,
  output logic [N_PORTS*OUT_W-1:0]   out_data
);

  // Captured configuration
  logic [N_PORTS-1:0]       offbin_q;
  logic [N_PORTS*SH_W-1:0]  shift_q;
  lane_mode_e               mode_q;
  logic [N_PORTS*SEL_W-1:0] sel_q;
  logic                     tbus_q;
  logic [N_PORTS*DLY_W-1:0] dly_q;

  always_ff @(posedge clk) begin
    if (rst || cfg_load) begin
      offbin_q <= cfg_offbin;
      shift_q  <= cfg_shift;
      mode_q   <= cfg_cplx ? LANE_CPLX : LANE_REAL;
      sel_q    <= cfg_iq_sel;
      tbus_q   <= cfg_tbus_en;
      dly_q    <= cfg_dly;
    end
  end

  logic [OUT_W-1:0] port_conv [N_PORTS];
  logic [OUT_W-1:0] lane_comb [N_PORTS];
  logic [OUT_W-1:0] lane_q    [N_PORTS];
  logic             lane_vld_q;
  logic [N_PORTS-1:0] lane_out_vld;

  for (genvar p = 0; p < N_PORTS; p++) begin : g_fmt
    rxc_port_fmt #(
      .IN_W(IN_W), .OUT_W(OUT_W), .SH_W(SH_W), .SHIFT_MAX(SHIFT_MAX)
    ) u_fmt (
      .raw   (in_data[p*IN_W +: IN_W]),
      .offbin(offbin_q[p]),
      .shift (shift_q[p*SH_W +: SH_W]),
      .conv  (port_conv[p])
    );
  end

  rxc_lane_map #(.N(N_PORTS), .W(OUT_W), .SEL_W(SEL_W)) u_map (
    .port_v(port_conv),
    .cplx  (mode_q == LANE_CPLX),
    .sel   (sel_q),
    .tbus  (tbus_q),
    .lane_v(lane_comb)
  );

  // Register stage between the conversion/routing logic and the buffers
  always_ff @(posedge clk) begin
    if (rst) begin
      lane_vld_q <= 1'b0;
      for (int k = 0; k < N_PORTS; k++) lane_q[k] <= '0;
    end else begin
      lane_vld_q <= in_valid;
      if (in_valid) begin
        for (int k = 0; k < N_PORTS; k++) lane_q[k] <= lane_comb[k];
      end
    end
  end

  for (genvar k = 0; k < N_PORTS; k++) begin : g_lane
    logic [DLY_W-1:0] eff_dly;
    if (k % 2 == 1) begin : g_partner
      assign eff_dly = (mode_q == LANE_CPLX) ? dly_q[(k-1)*DLY_W +: DLY_W]
                                             : dly_q[k*DLY_W +: DLY_W];
    end else begin : g_leader
      assign eff_dly = dly_q[k*DLY_W +: DLY_W];
    end

    rxc_delay_line #(.W(OUT_W), .DEPTH(MAX_DLY)) u_dly (
      .clk       (clk),
      .rst       (rst),
      .din_valid (lane_vld_q),
      .din       (lane_q[k]),
      .dly       (eff_dly),
      .dout_valid(lane_out_vld[k]),
      .dout      (out_data[k*OUT_W +: OUT_W])
    );
  end

  assign out_valid = &lane_out_vld;

  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !cfg_load |=> ($stable(offbin_q) && $stable(shift_q) && $stable(mode_q)
                   && $stable(sel_q) && $stable(tbus_q) && $stable(dly_q)));
  assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> lane_vld_q);

endmodule

// File: tb/tb_rx_input_cond.sv
module tb_rx_input_cond;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_load = 1'b0;
  logic [3:0]  cfg_offbin = '0;
  logic [11:0] cfg_shift = '0;
  logic        cfg_cplx = 1'b0;
  logic [7:0]  cfg_iq_sel = '0;
  logic        cfg_tbus_en = 1'b0;
  logic [23:0] cfg_dly = '0;
  logic        in_valid = 1'b0;
  logic [63:0] in_data = '0;
  logic        out_valid;
  logic [71:0] out_data;

  always #10 clk = ~clk;

  rx_input_cond dut (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_offbin(cfg_offbin),
    .cfg_shift(cfg_shift), .cfg_cplx(cfg_cplx), .cfg_iq_sel(cfg_iq_sel),
    .cfg_tbus_en(cfg_tbus_en), .cfg_dly(cfg_dly), .in_valid(in_valid),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Bench copy of the configuration the design should be using
  logic [3:0]  m_offbin;
  logic [11:0] m_shift;
  logic        m_cplx;
  logic [7:0]  m_sel;
  logic        m_tbus;
  logic [23:0] m_dly;

  logic [17:0] hist [4][0:1023];
  int in_n = 0;
  int out_n = 0;
  string tag = "R1";

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  function automatic logic [17:0] conv(input logic [15:0] raw, input logic ob,
                                       input logic [2:0] sh);
    logic [15:0] w;
    int x;
    int s;
    w = ob ? (raw ^ 16'h8000) : raw;
    x = $signed(w);
    x = x * 4;
    s = (sh > 3'd4) ? 4 : int'(sh);
    x = x >>> s;
    return x[17:0];
  endfunction

  function automatic logic [17:0] lane_exp(input int l, input logic [63:0] d);
    int src;
    src = m_cplx ? int'(m_sel[l*2 +: 2]) : l;
    if (m_tbus && src >= 2) return 18'd0;
    return conv(d[src*16 +: 16], m_offbin[src], m_shift[src*3 +: 3]);
  endfunction

  function automatic int eff_len(input int l);
    int f;
    if (m_cplx && (l % 2 == 1)) f = int'(m_dly[(l-1)*6 +: 6]);
    else                        f = int'(m_dly[l*6 +: 6]);
    return f + 1;
  endfunction

  function automatic logic [15:0] pick();
    case ($urandom % 8)
      0: return 16'h8000;
      1: return 16'h7FFF;
      2: return 16'h0000;
      3: return 16'hFFFF;
      default: return 16'($urandom);
    endcase
  endfunction

  task automatic snap_cfg();
    m_offbin = cfg_offbin; m_shift = cfg_shift; m_cplx = cfg_cplx;
    m_sel = cfg_iq_sel; m_tbus = cfg_tbus_en; m_dly = cfg_dly;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && out_data == '0, "R1", "outputs during reset",
          {31'd0, out_valid}, 32'd0);
    rst = 1'b0;
    snap_cfg();
    in_n = 0;
    out_n = 0;
    @(negedge clk);
    check(out_valid == 1'b0 && out_data == '0, "R1", "outputs after reset",
          out_data[31:0], 32'd0);
  endtask

  task automatic load_cfg();
    @(negedge clk);
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    snap_cfg();
  endtask

  task automatic push(input logic [63:0] d);
    in_valid = 1'b1;
    in_data = d;
    for (int l = 0; l < 4; l++) hist[l][in_n] = lane_exp(l, d);
    in_n++;
  endtask

  task automatic drive(input int n, input int pct);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (($urandom % 100) < pct) push({pick(), pick(), pick(), pick()});
      else begin
        in_valid = 1'b0;
        in_data = {4{16'($urandom)}};
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // Output monitor: every valid output is compared lane by lane with the history
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      for (int l = 0; l < 4; l++) begin
        int dl;
        logic [17:0] e;
        dl = eff_len(l);
        e = (out_n >= dl) ? hist[l][out_n - dl] : 18'd0;
        check(out_data[l*18 +: 18] == e, (out_n < dl) ? "R1" : tag,
              $sformatf("lane%0d output %0d", l, out_n),
              {14'd0, out_data[l*18 +: 18]}, {14'd0, e});
      end
      out_n++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7301));

    // R1: reset state
    tag = "R1";
    do_reset();

    // R4: real mode, two's complement, no shift
    tag = "R4";
    cfg_cplx = 1'b0; cfg_offbin = 4'h0; cfg_shift = '0;
    cfg_dly = {6'd5, 6'd3, 6'd1, 6'd0};
    do_reset();
    drive(150, 80);

    // R6: mixed delays, including the full 64-sample depth on lane 3
    tag = "R6";
    cfg_offbin = 4'($urandom); cfg_shift = 12'($urandom);
    cfg_dly = {6'd63, 6'($urandom % 64), 6'($urandom % 64), 6'd0};
    do_reset();
    drive(320, 95);

    // R2: offset-binary on every port
    tag = "R2";
    cfg_offbin = 4'hF; cfg_shift = '0; cfg_dly = '0;
    do_reset();
    drive(100, 90);

    // R3: headroom shifts 1, 2, 4 and a clamped 7
    tag = "R3";
    cfg_offbin = 4'b0101; cfg_shift = {3'd7, 3'd4, 3'd2, 3'd1};
    cfg_dly = {6'd2, 6'd2, 6'd2, 6'd2};
    do_reset();
    drive(120, 85);

    // R8: sparse valid samples, then a single-sample latency probe
    tag = "R8";
    cfg_offbin = 4'($urandom); cfg_shift = 12'($urandom);
    cfg_dly = {6'd4, 6'd9, 6'd1, 6'd6};
    do_reset();
    drive(200, 25);
    @(negedge clk);
    push(64'h1234_8765_0F0F_F0F0);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b0, "R8", "valid one cycle after input", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    check(out_valid == 1'b1, "R8", "valid two cycles after input", {31'd0, out_valid}, 32'd1);
    @(negedge clk);
    check(out_valid == 1'b0, "R8", "valid three cycles after input", {31'd0, out_valid}, 32'd0);
    repeat (3) @(negedge clk);

    // R5: complex pairing with random port selection
    tag = "R5";
    cfg_cplx = 1'b1; cfg_iq_sel = 8'($urandom);
    cfg_offbin = 4'($urandom); cfg_shift = 12'($urandom);
    cfg_dly = 24'($urandom) & 24'h1F7DF7;
    do_reset();
    drive(160, 80);

    // R7: partner lanes must follow the leader's delay, own field ignored
    tag = "R7";
    cfg_iq_sel = 8'b00_01_10_11;
    cfg_dly = {6'd1, 6'd40, 6'd50, 6'd3};
    do_reset();
    drive(200, 90);

    // R9: ports C and D unavailable; lanes 0 and 1 sourced from them
    tag = "R9";
    cfg_tbus_en = 1'b1; cfg_cplx = 1'b1;
    cfg_iq_sel = {2'd1, 2'd0, 2'd3, 2'd2};
    cfg_offbin = 4'hF; cfg_dly = {6'd2, 6'd0, 6'd1, 6'd0};
    do_reset();
    drive(100, 85);

    // R10: configuration changes without a load strobe are ignored
    tag = "R10";
    cfg_tbus_en = 1'b0; cfg_cplx = 1'b0; cfg_offbin = 4'h3;
    cfg_shift = {3'd0, 3'd1, 3'd2, 3'd3}; cfg_dly = {6'd7, 6'd0, 6'd12, 6'd3};
    do_reset();
    drive(100, 85);
    @(negedge clk);
    cfg_cplx = 1'b1; cfg_iq_sel = 8'hE4 ^ 8'hFF; cfg_offbin = 4'hC;
    cfg_shift = 12'hFFF; cfg_dly = 24'h0;
    drive(100, 85);
    load_cfg();
    drive(100, 85);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule